// File: doc/BRIEF.md
# Two-Group Interrupt Enable and Pending Aggregator

This block gathers interrupt requests from two families of subsystems, a set of I2C masters and a set of GPIO lines, into one 32-bit pending word and one 32-bit enable word. Both words sit on a small memory-mapped register bus. A source pulse latches its pending bit whether or not that bit is enabled. Software clears a pending bit by writing a 1 to it, and writing 0 leaves the bit as it is.

A static layout strap picks how the 32-bit word is divided between the two families. In the default layout the I2C field is bits 15:0 and the GPIO field is bits 31:16. In the alternate layout the I2C field is bits 7:0 and the GPIO field is bits 28:12. Bits outside both fields do not exist: they read as zero and ignore writes.

The block drives one level-sensitive interrupt line and one summary line per family. Each output is high while at least one bit that is both pending and enabled lies in the relevant field. All outputs are registered.

Top module: `irq_collect`

## Requirements
- R1: After synchronous reset both registers read 0 and `irq_out`, `i2c_sum` and `gpio_sum` are low.
- R2: The enable register is at offset 0x104 and is read/write. Bits outside the active layout's fields read 0.
- R3: A source pulse sets its pending bit at the clock edge whatever the enable state, and the bit stays set until cleared. The pending register is at offset 0x108.
- R4: A write to 0x108 clears each pending bit written as 1 and leaves each bit written as 0 unchanged. A write to 0x104 does not touch the pending bits.
- R5: When a source sets a pending bit in the same cycle as a write-1-to-clear of that bit, the bit ends up set.
- R6: Default layout (`layout_alt`=0): `i2c_src[i]` maps to bit i for i in 0..15, and `gpio_src[j]` maps to bit 16+j for j in 0..15. `gpio_src[16]` is ignored.
- R7: Alternate layout (`layout_alt`=1): `i2c_src[i]` maps to bit i for i in 0..7, and `gpio_src[j]` maps to bit 12+j for j in 0..16. `i2c_src[15:8]` is ignored, and bits 11:8 and 31:29 stay 0.
- R8: `i2c_sum` (or `gpio_sum`) is high one cycle after the AND of pending and enable has a set bit in the I2C (or GPIO) field, and low otherwise. Pending bits that are not enabled do not raise a summary.
- R9: `irq_out` is high one cycle after any pending bit that is also enabled exists. It stays high until every such bit is cleared or disabled, and it always equals `i2c_sum` OR `gpio_sum`.
- R10: `bus_rdata` shows the addressed register one cycle after `bus_ren`, as it stood before that edge's updates. Otherwise it is 0, and reads of any other offset return 0. Writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| layout_alt | input | 1 | Layout strap: 0 default split, 1 alternate split |
| i2c_src | input | 16 | I2C source event pulses, one cycle each |
| gpio_src | input | 17 | GPIO source event pulses, one cycle each |
| bus_addr | input | 12 | Register byte offset |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Level interrupt, any enabled pending bit |
| i2c_sum | output | 1 | Enabled pending bit present in I2C field |
| gpio_sum | output | 1 | Enabled pending bit present in GPIO field |

## Verification
The bound checker watches several properties on every cycle. It checks that no register bit outside the active fields is ever set. It checks that a pending bit never drops unless it was cleared, and never rises without a source event. It checks that set beats clear, that each summary follows the enabled-pending word of its field with one cycle of delay, and that the interrupt line is the OR of the summaries. Other behaviour can only be shown by the bench scenarios. These cover the exact bit position each source lands on in either layout, ignored source bits, the read latency and the values returned, zero reads of unmapped offsets, and a pending event that only raises the interrupt once its enable bit is written later.

// File: rtl/irq_collect_pkg.sv
package irq_collect_pkg;
  localparam int REG_W = 32;

  // Contiguous mask of w bits starting at bit lo.
  function automatic logic [REG_W-1:0] field_mask(input int lo, input int w);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) begin
      m[i] = (i >= lo) && (i < lo + w);
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_field_map.sv
module irq_field_map
  import irq_collect_pkg::*;
#(
  parameter int I2C_W_DEF   = 16,
  parameter int GPIO_SH_DEF = 16,
  parameter int GPIO_W_DEF  = 16,
  parameter int I2C_W_ALT   = 8,
  parameter int GPIO_SH_ALT = 12,
  parameter int GPIO_W_ALT  = 17,
  parameter int I2C_SRC_W   = 16,
  parameter int GPIO_SRC_W  = 17
) (
  input  logic                  layout_alt,
  input  logic [I2C_SRC_W-1:0]  i2c_src,
  input  logic [GPIO_SRC_W-1:0] gpio_src,
  output logic [REG_W-1:0]      set_vec,
  output logic [REG_W-1:0]      i2c_mask,
  output logic [REG_W-1:0]      gpio_mask
);
  localparam int NLAYOUT = 2;

  logic [REG_W-1:0] i2c_ext;
  logic [REG_W-1:0] gpio_ext;
  logic [REG_W-1:0] set_l   [NLAYOUT];
  logic [REG_W-1:0] i2c_m_l [NLAYOUT];
  logic [REG_W-1:0] gpio_m_l[NLAYOUT];

  assign i2c_ext  = REG_W'(i2c_src);
  assign gpio_ext = REG_W'(gpio_src);

  for (genvar g = 0; g < NLAYOUT; g++) begin : g_layout
    localparam int IW = (g == 0) ? I2C_W_DEF   : I2C_W_ALT;
    localparam int GS = (g == 0) ? GPIO_SH_DEF : GPIO_SH_ALT;
    localparam int GW = (g == 0) ? GPIO_W_DEF  : GPIO_W_ALT;
    localparam logic [REG_W-1:0] IM = field_mask(0, IW);
    localparam logic [REG_W-1:0] GM = field_mask(GS, GW);
    assign i2c_m_l[g]  = IM;
    assign gpio_m_l[g] = GM;
    assign set_l[g]    = (i2c_ext & IM) | ((gpio_ext << GS) & GM);
  end

  assign set_vec   = layout_alt ? set_l[1]    : set_l[0];
  assign i2c_mask  = layout_alt ? i2c_m_l[1]  : i2c_m_l[0];
  assign gpio_mask = layout_alt ? gpio_m_l[1] : gpio_m_l[0];
endmodule

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
  import irq_collect_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] ENA_OFF  = 12'h104,
  parameter logic [ADDR_W-1:0] PEND_OFF = 12'h108
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_ren,
  input  logic [REG_W-1:0]  set_vec,
  input  logic [REG_W-1:0]  valid_mask,
  output logic [REG_W-1:0]  en_q,
  output logic [REG_W-1:0]  pend_q,
  output logic [REG_W-1:0]  clr_vec,
  output logic [REG_W-1:0]  bus_rdata
);
  logic hit_en_wr;
  logic [REG_W-1:0] rd_sel;

  assign hit_en_wr = bus_wen && (bus_addr == ENA_OFF);
  assign clr_vec   = (bus_wen && (bus_addr == PEND_OFF)) ? bus_wdata : '0;

  always_comb begin
    rd_sel = '0;
    if (bus_addr == ENA_OFF)       rd_sel = en_q;
    else if (bus_addr == PEND_OFF) rd_sel = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      pend_q    <= '0;
      bus_rdata <= '0;
    end else begin
      en_q      <= (hit_en_wr ? bus_wdata : en_q) & valid_mask;
      pend_q    <= ((pend_q & ~clr_vec) | set_vec) & valid_mask;
      bus_rdata <= bus_ren ? rd_sel : '0;
    end
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_collect_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] en_q,
  input  logic [REG_W-1:0] pend_q,
  input  logic [REG_W-1:0] i2c_mask,
  input  logic [REG_W-1:0] gpio_mask,
  output logic             irq_out,
  output logic             i2c_sum,
  output logic             gpio_sum
);
  logic [REG_W-1:0] live;
  assign live = en_q & pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out  <= 1'b0;
      i2c_sum  <= 1'b0;
      gpio_sum <= 1'b0;
    end else begin
      irq_out  <= |live;
      i2c_sum  <= |(live & i2c_mask);
      gpio_sum <= |(live & gpio_mask);
    end
  end
endmodule

// File: rtl/irq_collect.sv
module irq_collect
  import irq_collect_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] ENA_OFF     = 12'h104,
  parameter logic [ADDR_W-1:0] PEND_OFF    = 12'h108,
  parameter int                I2C_W_DEF   = 16,
  parameter int                GPIO_SH_DEF = 16,
  parameter int                GPIO_W_DEF  = 16,
  parameter int                I2C_W_ALT   = 8,
  parameter int                GPIO_SH_ALT = 12,
  parameter int                GPIO_W_ALT  = 17,
  localparam int I2C_SRC_W  = (I2C_W_DEF > I2C_W_ALT) ? I2C_W_DEF : I2C_W_ALT,
  localparam int GPIO_SRC_W = (GPIO_W_DEF > GPIO_W_ALT) ? GPIO_W_DEF : GPIO_W_ALT
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  layout_alt,
  input  logic [I2C_SRC_W-1:0]  i2c_src,
  input  logic [GPIO_SRC_W-1:0] gpio_src,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wen,
  input  logic [REG_W-1:0]      bus_wdata,
  input  logic                  bus_ren,
  output logic [REG_W-1:0]      bus_rdata,
  output logic                  irq_out,
  output logic                  i2c_sum,
  output logic                  gpio_sum
);
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] i2c_mask;
  logic [REG_W-1:0] gpio_mask;
  logic [REG_W-1:0] valid_mask;
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] pend_q;

  assign valid_mask = i2c_mask | gpio_mask;

  irq_field_map #(
    .I2C_W_DEF(I2C_W_DEF), .GPIO_SH_DEF(GPIO_SH_DEF), .GPIO_W_DEF(GPIO_W_DEF),
    .I2C_W_ALT(I2C_W_ALT), .GPIO_SH_ALT(GPIO_SH_ALT), .GPIO_W_ALT(GPIO_W_ALT),
    .I2C_SRC_W(I2C_SRC_W), .GPIO_SRC_W(GPIO_SRC_W)
  ) u_map (
    .layout_alt(layout_alt),
    .i2c_src(i2c_src),
    .gpio_src(gpio_src),
    .set_vec(set_vec),
    .i2c_mask(i2c_mask),
    .gpio_mask(gpio_mask)
  );

  irq_bus_regs #(
    .ADDR_W(ADDR_W), .ENA_OFF(ENA_OFF), .PEND_OFF(PEND_OFF)
  ) u_regs (
    .clk(clk),
    .rst(rst),
    .bus_addr(bus_addr),
    .bus_wen(bus_wen),
    .bus_wdata(bus_wdata),
    .bus_ren(bus_ren),
    .set_vec(set_vec),
    .valid_mask(valid_mask),
    .en_q(en_q),
    .pend_q(pend_q),
    .clr_vec(clr_vec),
    .bus_rdata(bus_rdata)
  );

  irq_summary u_sum (
    .clk(clk),
    .rst(rst),
    .en_q(en_q),
    .pend_q(pend_q),
    .i2c_mask(i2c_mask),
    .gpio_mask(gpio_mask),
    .irq_out(irq_out),
    .i2c_sum(i2c_sum),
    .gpio_sum(gpio_sum)
  );
endmodule

// File: rtl/irq_collect_chk.sv
module irq_collect_chk
  import irq_collect_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] en_q,
  input logic [REG_W-1:0] pend_q,
  input logic [REG_W-1:0] set_vec,
  input logic [REG_W-1:0] clr_vec,
  input logic [REG_W-1:0] valid_mask,
  input logic [REG_W-1:0] i2c_mask,
  input logic [REG_W-1:0] gpio_mask,
  input logic             irq_out,
  input logic             i2c_sum,
  input logic             gpio_sum
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_out && !i2c_sum && !gpio_sum && en_q == '0 && pend_q == '0));

  a_r2_enable_in_field: assert property (@(posedge clk) disable iff (rst)
    (en_q & ~valid_mask) == '0);

  a_r7_pend_in_field: assert property (@(posedge clk) disable iff (rst)
    (pend_q & ~valid_mask) == '0);

  // R3 and R5: a bit only drops when cleared without a same-cycle set
  a_r3_sticky_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((((($past(pend_q) & ~$past(clr_vec)) | $past(set_vec))
                       & $past(valid_mask)) & ~pend_q) == '0));

  a_r4_no_stray_set: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0));

  a_r4_clear_takes: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend_q & $past(clr_vec) & ~$past(set_vec)) == '0));

  a_r8_i2c_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (i2c_sum == (|($past(pend_q) & $past(en_q) & $past(i2c_mask)))));

  a_r8_gpio_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (gpio_sum == (|($past(pend_q) & $past(en_q) & $past(gpio_mask)))));

  a_r9_irq_is_or: assert property (@(posedge clk) disable iff (rst)
    irq_out == (i2c_sum || gpio_sum));
endmodule

bind irq_collect irq_collect_chk u_chk (
  .clk(clk),
  .rst(rst),
  .en_q(en_q),
  .pend_q(pend_q),
  .set_vec(set_vec),
  .clr_vec(clr_vec),
  .valid_mask(valid_mask),
  .i2c_mask(i2c_mask),
  .gpio_mask(gpio_mask),
  .irq_out(irq_out),
  .i2c_sum(i2c_sum),
  .gpio_sum(gpio_sum)
);

// File: tb/sim_irq_collect.sv
`timescale 1ns/1ps
module sim_irq_collect;
  localparam logic [11:0] A_EN   = 12'h104;
  localparam logic [11:0] A_PEND = 12'h108;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        layout_alt = 1'b0;
  logic [15:0] i2c_src = '0;
  logic [16:0] gpio_src = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ren = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_out, i2c_sum, gpio_sum;

  int n_chk = 0;
  int n_bad = 0;
  string phase = "R1";
  logic done = 1'b0;

  always #4 clk = ~clk;

  irq_collect u0 (
    .clk(clk), .rst(rst), .layout_alt(layout_alt),
    .i2c_src(i2c_src), .gpio_src(gpio_src),
    .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
    .bus_ren(bus_ren), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .i2c_sum(i2c_sum), .gpio_sum(gpio_sum)
  );

  // Behavioural reference model
  logic [31:0] m_en = '0, m_pend = '0, e_rdata = '0;
  logic        e_irq = 1'b0, e_i2c = 1'b0, e_gpio = 1'b0;

  function automatic bit in_i2c(input int b, input logic alt);
    return alt ? (b < 8) : (b < 16);
  endfunction
  function automatic bit in_gpio(input int b, input logic alt);
    return alt ? (b >= 12 && b <= 28) : (b >= 16);
  endfunction

  always @(posedge clk) begin
    logic [31:0] setv, clrv, live;
    if (rst) begin
      m_en = '0; m_pend = '0; e_rdata = '0;
      e_irq = 0; e_i2c = 0; e_gpio = 0;
    end else begin
      live = m_en & m_pend;
      e_irq = (live != 0);
      e_i2c = 0; e_gpio = 0;
      for (int b = 0; b < 32; b++) begin
        if (live[b] && in_i2c(b, layout_alt))  e_i2c = 1;
        if (live[b] && in_gpio(b, layout_alt)) e_gpio = 1;
      end
      if (!bus_ren) e_rdata = '0;
      else if (bus_addr == A_EN) e_rdata = m_en;
      else if (bus_addr == A_PEND) e_rdata = m_pend;
      else e_rdata = '0;
      setv = '0;
      for (int i = 0; i < 16; i++)
        if (i2c_src[i] && in_i2c(i, layout_alt)) setv[i] = 1;
      for (int j = 0; j < 17; j++) begin
        int pos;
        pos = (layout_alt ? 12 : 16) + j;
        if (gpio_src[j] && pos < 32 && in_gpio(pos, layout_alt)) setv[pos] = 1;
      end
      clrv = (bus_wen && bus_addr == A_PEND) ? bus_wdata : '0;
      m_pend = (m_pend & ~clrv) | setv;
      if (bus_wen && bus_addr == A_EN) m_en = bus_wdata;
      for (int b = 0; b < 32; b++)
        if (!(in_i2c(b, layout_alt) || in_gpio(b, layout_alt))) begin
          m_en[b] = 0; m_pend[b] = 0;
        end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check({phase, " rdata"}, bus_rdata, e_rdata);
      check({phase, " irq_out"}, {31'b0, irq_out}, {31'b0, e_irq});
      check({phase, " i2c_sum"}, {31'b0, i2c_sum}, {31'b0, e_i2c});
      check({phase, " gpio_sum"}, {31'b0, gpio_sum}, {31'b0, e_gpio});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_ren = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_ren = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] iv, input logic [16:0] gv);
    @(negedge clk);
    i2c_src = iv; gpio_src = gv;
    @(negedge clk);
    i2c_src = '0; gpio_src = '0;
  endtask

  task automatic do_reset(input logic alt);
    @(negedge clk);
    rst = 1'b1; layout_alt = alt;
    tick(3);
    rst = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    tick(3);
    rst = 1'b0;
    tick(1);
    phase = "R1";
    rd(A_EN, v);   check("R1 enable after reset", v, 32'h0);
    rd(A_PEND, v); check("R1 pending after reset", v, 32'h0);
    check("R1 irq after reset", {31'b0, irq_out}, 32'h0);

    phase = "R2";
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v); check("R2 enable readback default", v, 32'hFFFF_FFFF);
    wr(A_EN, 32'h0);

    phase = "R3";
    pulse(16'h0008, '0);
    tick(1);
    rd(A_PEND, v); check("R3 pending set while disabled", v, 32'h0000_0008);
    check("R3 irq stays low while disabled", {31'b0, irq_out}, 32'h0);
    wr(A_EN, 32'h0000_0008);
    tick(1);
    check("R9 irq rises after late enable", {31'b0, irq_out}, 32'h1);
    check("R8 i2c_sum after late enable", {31'b0, i2c_sum}, 32'h1);

    phase = "R4";
    wr(A_PEND, 32'h0);
    rd(A_PEND, v); check("R4 write 0 keeps pending", v, 32'h0000_0008);
    wr(A_EN, 32'h0000_0008);
    rd(A_PEND, v); check("R4 enable write keeps pending", v, 32'h0000_0008);
    wr(A_PEND, 32'h0000_0008);
    tick(1);
    rd(A_PEND, v); check("R4 write 1 clears", v, 32'h0);
    check("R9 irq falls after clear", {31'b0, irq_out}, 32'h0);

    phase = "R5";
    @(negedge clk);
    i2c_src = 16'h0020; bus_addr = A_PEND; bus_wdata = 32'h0000_0020; bus_wen = 1'b1;
    @(negedge clk);
    i2c_src = '0; bus_wen = 1'b0;
    rd(A_PEND, v); check("R5 set beats clear", v, 32'h0000_0020);
    wr(A_PEND, 32'hFFFF_FFFF);

    phase = "R6";
    pulse(16'h8001, 17'h1_8001);
    rd(A_PEND, v); check("R6 default mapping", v, 32'h8001_8001);
    wr(A_EN, 32'h0001_0000);
    tick(1);
    check("R8 gpio_sum enabled", {31'b0, gpio_sum}, 32'h1);
    check("R8 i2c_sum disabled pending", {31'b0, i2c_sum}, 32'h0);
    wr(A_PEND, 32'h0001_0000);
    tick(1);
    check("R8 gpio_sum with only disabled pending", {31'b0, gpio_sum}, 32'h0);
    check("R9 irq low with only disabled pending", {31'b0, irq_out}, 32'h0);

    phase = "R10";
    wr(12'h10C, 32'hFFFF_FFFF);
    rd(12'h10C, v); check("R10 unmapped read zero", v, 32'h0);
    rd(A_EN, v);    check("R10 unmapped write no effect", v, 32'h0001_0000);

    phase = "R7";
    do_reset(1'b1);
    tick(1);
    pulse(16'hFF00, '0);
    rd(A_PEND, v); check("R7 upper i2c ignored", v, 32'h0);
    pulse(16'h0081, 17'h1_0001);
    rd(A_PEND, v); check("R7 alternate mapping", v, 32'h1000_1081);
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v); check("R7 enable field bits only", v, 32'h1FFF_F0FF);
    tick(1);
    check("R8 alt i2c_sum", {31'b0, i2c_sum}, 32'h1);
    check("R8 alt gpio_sum", {31'b0, gpio_sum}, 32'h1);
    wr(A_PEND, 32'hFFFF_FFFF);
    tick(2);
    check("R9 alt irq cleared", {31'b0, irq_out}, 32'h0);

    tick(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule